// File: doc/BRIEF.md
# Conversion Readback Delay Timer

This block holds off the readback of a daisy-chained battery-monitor conversion until every device in the chain has finished converting. A single-cycle trigger marks the moment the conversion-start command has left the host. On that edge the block takes the acquisition-time code, the averaging code and the number of devices beyond the first. From these it works out the required wait in nanoseconds, rounds it up to whole microseconds, adds a fixed settling margin, and converts the result into system clock cycles.

A down-counter then runs out that many cycles and raises a one-cycle done pulse, which the receive path uses as its permission to start clocking data in. While the count runs, busy is high. A new trigger during a count throws the old one away and starts again from the configuration present on the new trigger edge.

Top module: `rbd_readback_timer`

## Requirements
- R1: After reset, `done` and `busy` are both low and stay low until a trigger arrives.
- R2: The acquisition time used for each code is: 0 gives 470 ns, 1 gives 1030 ns, 2 gives 1510 ns, 3 gives 1945 ns.
- R3: The number of averaged samples for each averaging code is: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
- R4: Every device after the first adds 250 ns to the nanosecond total, for 0 to 7 extra devices.
- R5: The nanosecond total is (tacq + 720) x (12 x samples) - tacq + extra x 250. It is rounded up to the next whole microsecond, and 5 us is added. A total that is already a whole number of microseconds is not rounded further.
- R6: With N = wait_us x CLK_PER_US, `done` is high for exactly one cycle. It rises in the cycle that follows clock edge t0+N, where t0 is the edge on which `trig` was sampled high.
- R7: `busy` is high from the cycle after a trigger edge until the edge that raises `done`. It is never high in the same cycle as `done`.
- R8: A trigger that arrives while `busy` is high restarts the count from the configuration sampled on that new edge. The earlier count produces no `done`.
- R9: Changes on `acq_code`, `avg_code` or `chain_extra` after the trigger edge have no effect on the running count.
- R10: The counter holds the worst-case wait (code 3, code 3, 7 extra devices: 261 us) without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Conversion-start command sent; samples the configuration |
| acq_code | input | 2 | Acquisition-time code |
| avg_code | input | 2 | Averaging code |
| chain_extra | input | $clog2(MAX_DEVS) | Number of chained devices beyond the first |
| busy | output | 1 | A wait is being counted out |
| done | output | 1 | One-cycle pulse: readback may start |

## Verification
Each trigger has a single result, the done pulse. That pulse is due exactly N cycles after the edge that sampled the trigger, and busy is due one cycle after that edge. The driver notes the edge number at which each trigger is sampled and computes N from its own statement of the formula. It then queues the absolute cycle at which done must appear. On a retrigger it removes the pending entry. The monitor samples shortly after every rising edge, so a done that comes one cycle early or late, or that never comes, is reported against the entry.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int unsigned CONV_NS        = 720;
  localparam int unsigned CH_PER_DEVICE  = 12;
  localparam int unsigned DEV_PENALTY_NS = 250;
  localparam int unsigned SETTLE_US      = 5;
  localparam int unsigned NS_PER_US      = 1000;

  // acquisition time in ns for a 2-bit code
  function automatic int unsigned acq_ns(input logic [1:0] code);
    case (code)
      2'd0:    return 470;
      2'd1:    return 1030;
      2'd2:    return 1510;
      default: return 1945;
    endcase
  endfunction

  // number of averaged samples per channel: 1, 2, 4, 8
  function automatic int unsigned avg_count(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  function automatic int unsigned wait_ns(input logic [1:0] acq, input logic [1:0] avg,
                                          input int unsigned extra);
    int unsigned t;
    t = acq_ns(acq);
    return (t + CONV_NS) * (CH_PER_DEVICE * avg_count(avg)) - t + DEV_PENALTY_NS * extra;
  endfunction

  // ceiling to whole microseconds plus the settling margin
  function automatic int unsigned wait_us(input logic [1:0] acq, input logic [1:0] avg,
                                          input int unsigned extra);
    return (wait_ns(acq, avg, extra) + NS_PER_US - 1) / NS_PER_US + SETTLE_US;
  endfunction
endpackage

// File: rtl/rbd_wait_calc.sv
module rbd_wait_calc #(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned EW         = 3,
  parameter int unsigned CW         = 11
) (
  input  logic [1:0]    acq_code,
  input  logic [1:0]    avg_code,
  input  logic [EW-1:0] chain_extra,
  output logic [CW-1:0] cycles
);
  int unsigned us_total;

  always_comb begin
    us_total = rbd_pkg::wait_us(acq_code, avg_code, int'(chain_extra));
    cycles   = CW'(us_total * CLK_PER_US);
  end
endmodule

// File: rtl/rbd_countdown.sv
module rbd_countdown #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic [CW-1:0] remain,
  output logic          expire
);
  logic last_tick;
  assign last_tick = busy && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      expire <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= load_val;
      expire <= 1'b0;
    end else if (last_tick) begin
      busy   <= 1'b0;
      remain <= '0;
      expire <= 1'b1;
    end else begin
      expire <= 1'b0;
      if (busy) remain <= remain - CW'(1);
    end
  end
endmodule

// File: rtl/rbd_readback_timer.sv
module rbd_readback_timer #(
  parameter int unsigned CLK_PER_US = 4,
  parameter int unsigned MAX_DEVS   = 8,
  localparam int unsigned EW = (MAX_DEVS > 1) ? $clog2(MAX_DEVS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [1:0]    acq_code,
  input  logic [1:0]    avg_code,
  input  logic [EW-1:0] chain_extra,
  output logic          busy,
  output logic          done
);
  localparam int unsigned MAX_CYCLES =
    rbd_pkg::wait_us(2'd3, 2'd3, MAX_DEVS - 1) * CLK_PER_US;
  localparam int unsigned MIN_CYCLES =
    rbd_pkg::wait_us(2'd0, 2'd0, 0) * CLK_PER_US;
  localparam int unsigned CW = $clog2(MAX_CYCLES + 1);

  // event wires brought out for the checker
  logic [CW-1:0] load_cycles;
  logic [CW-1:0] remain;

  rbd_wait_calc #(.CLK_PER_US(CLK_PER_US), .EW(EW), .CW(CW)) u_calc (
    .acq_code    (acq_code),
    .avg_code    (avg_code),
    .chain_extra (chain_extra),
    .cycles      (load_cycles)
  );

  rbd_countdown #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (trig),
    .load_val (load_cycles),
    .busy     (busy),
    .remain   (remain),
    .expire   (done)
  );
endmodule

// File: rtl/rbd_readback_timer_chk.sv
module rbd_readback_timer_chk #(
  parameter int unsigned CW         = 11,
  parameter int unsigned MIN_CYCLES = 76
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] load_cycles,
  input logic [CW-1:0] remain
);
  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: done only ends a running count
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R7 / R8: a trigger starts busy and suppresses any done
  a_r8_trig_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (busy && !done));
  // R7: busy and done never together
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R9: a running count only steps down by one
  a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trig && remain > CW'(1)) |=> (busy && remain == $past(remain) - CW'(1)));
  // R10: loaded wait never wraps below the shortest legal wait
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (load_cycles >= CW'(MIN_CYCLES)));
endmodule

bind rbd_readback_timer rbd_readback_timer_chk #(.CW(CW), .MIN_CYCLES(MIN_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig        (trig),
  .busy        (busy),
  .done        (done),
  .load_cycles (load_cycles),
  .remain      (remain)
);

// File: tb/tb_rbd_readback_timer.sv
module tb_rbd_readback_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [1:0] acq_code = '0, avg_code = '0;
  logic [2:0] chain_extra = '0;
  logic busy, done;

  typedef struct { int due; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rbd_readback_timer #(.CLK_PER_US(CPU), .MAX_DEVS(8)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .acq_code(acq_code),
    .avg_code(avg_code), .chain_extra(chain_extra), .busy(busy), .done(done));

  // expected wait restated: table lookup, shift, loop ceiling
  function automatic int exp_cycles(int a, int v, int e);
    int tacq[4] = '{470, 1030, 1510, 1945};
    int ns, us;
    ns = (tacq[a] + 720) * 12 * (1 << v) - tacq[a] + 250 * e;
    us = 0;
    while (us * 1000 < ns) us++;
    return (us + 5) * CPU;
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: pulse trig for one edge and push the expected done cycle
  task automatic fire(int a, int v, int e, string req);
    exp_t it;
    @(negedge clk);
    acq_code = 2'(a); avg_code = 2'(v); chain_extra = 3'(e); trig = 1'b1;
    q.delete();
    it.due = cyc + 1 + exp_cycles(a, v, e);
    it.req = req;
    q.push_back(it);
    @(negedge clk);
    trig = 1'b0;
    check({req, "/R7 busy after trigger"}, int'(busy), 1);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: sample after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (q.size() != 0 && cyc == q[0].due) begin
          check({q[0].req, "/R6 done due"}, int'(done), 1);
          check({q[0].req, "/R7 busy low at done"}, int'(busy), 0);
          void'(q.pop_front());
        end else if (done) begin
          check("R6/R8 unexpected done", 1, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 busy after reset", int'(busy), 0);

    // R2: acquisition codes (76, 100, 124, 144 cycles)
    check("R2 self 0", exp_cycles(0,0,0), 76);
    fire(0, 0, 0, "R2 acq0"); wait_idle();
    fire(1, 0, 0, "R2 acq1"); wait_idle();
    fire(2, 0, 0, "R2 acq2"); wait_idle();
    fire(3, 0, 0, "R2 acq3"); wait_idle();
    // R3: averaging codes
    fire(0, 1, 0, "R3 avg2"); wait_idle();
    fire(0, 2, 0, "R3 avg4"); wait_idle();
    fire(0, 3, 0, "R3 avg8"); wait_idle();
    // R4: device penalty
    fire(0, 0, 7, "R4 extra7"); wait_idle();
    fire(1, 1, 2, "R4 extra2"); wait_idle();
    // R5: exact microsecond (26000 ns -> 31 us) and just above
    check("R5 exact total", exp_cycles(2,0,3), 124);
    fire(2, 0, 3, "R5 exact"); wait_idle();
    fire(2, 0, 4, "R5 above"); wait_idle();
    // R10: worst case 261 us
    check("R10 worst total", exp_cycles(3,3,7), 1044);
    fire(3, 3, 7, "R10 worst"); wait_idle();
    // R8: retrigger in mid count, and on consecutive edges
    fire(3, 3, 7, "R8 first");
    repeat (100) @(negedge clk);
    fire(0, 0, 0, "R8 restart"); wait_idle();
    fire(3, 0, 0, "R8 back0");
    fire(1, 0, 1, "R8 back1"); wait_idle();
    // R9: inputs changed right after the trigger edge are ignored
    fire(0, 0, 0, "R9 hold");
    acq_code = 2'd3; avg_code = 2'd3; chain_extra = 3'd7;
    wait_idle();
    check("R1 idle at end", int'(busy), 0);
    report();
  end
endmodule